// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which UART interrupt source the CPU should see and how that source is cleared. It watches four sources. Receive line errors arrive as a one-cycle event that is held until software reads line status. Receive data available is a level that follows the receive FIFO fill against a selectable threshold. Character timeout comes from an internal idle timer. Transmit-holding-empty is raised on the edge where the holding register becomes empty while that source is enabled.

Only the highest-priority source that is pending and enabled is reported. It appears on a 4-bit identification value whose bit 0 is an active-low pending flag, and also on an active-high request line. The FIFOs, the shifters and the bus decoder are outside the block. Their effects arrive as plain inputs: the fill level, push and pop strobes, and read and write strobes for the relevant registers.

The idle timer counts baud ticks. A tick is one sixteenth of a bit time. The timer restarts whenever a byte enters or leaves the receive FIFO, and whenever the FIFO is empty. It fires after four character times, which lies inside the required 3.5 to 4.5 character window.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with all inputs low, `iir` is 4'b0001 and `irq` is 0.
- R2: `iir[0]` is 0 exactly when an interrupt is reported and 1 otherwise. `irq` is the inverse of `iir[0]`. `iir[3:1]` carries the source code: 3 line status, 2 data available, 6 timeout, 1 transmit empty, 0 none.
- R3: A cycle with `rx_err_set` high latches a line-status source. From the next cycle, with `ier[2]` set, it is reported as code 3 (`iir` = 4'b0110). It stays until a cycle with `lsr_rd` high, after which it is gone.
- R4: With `ier[0]` set, data available (code 2, `iir` = 4'b0100) is reported while `rx_level` is at or above the trigger level. It disappears as soon as the level drops below the trigger.
- R5: `trig_sel` selects the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. One byte below the level, no data-available source is reported.
- R6: With `rx_level` non-zero and no push or pop, the timeout (code 6, `iir` = 4'b1100) is reported after exactly `frame_bits`×64 counted baud ticks (four characters of 16 ticks per bit), and not one tick earlier.
- R7: A cycle with `rx_pop` or `rx_push` high clears a pending timeout from the next cycle on and restarts the idle count from zero.
- R8: Transmit-empty (code 1, `iir` = 4'b0010) is raised in the cycle after `thr_empty & ier[1]` rises. It is cleared by `thr_wr`, or by `iir_rd` in a cycle where code 1 is the reported source.
- R9: An `iir_rd` while another source is reported leaves a pending transmit-empty source in place, and it does not clear line status.
- R10: Priority from highest to lowest is line status, data available, timeout, transmit empty.
- R11: `ier[0]` gates data available and timeout, `ier[1]` gates transmit empty, and `ier[2]` gates line status. A latched line-status source masked by `ier[2]` is reported as soon as the bit is set. Setting `ier[1]` while the holding register is empty raises transmit empty.
- R12: The idle timer advances only in cycles with `baud_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier | input | 3 | Source enables: bit 0 receive data and timeout, bit 1 transmit empty, bit 2 line status |
| trig_sel | input | 2 | Receive trigger level select |
| frame_bits | input | FRAME_W | Bits per character frame, start and stop bits included |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | A byte was written into the receive FIFO |
| rx_pop | input | 1 | A byte was read from the receive FIFO |
| rx_err_set | input | 1 | A receive line error was detected |
| lsr_rd | input | 1 | Line status register read strobe |
| iir_rd | input | 1 | Identification register read strobe |
| thr_empty | input | 1 | Transmit holding register is empty |
| thr_wr | input | 1 | Transmit holding register write strobe |
| baud_tick | input | 1 | Sixteen-times oversampling tick |
| iir | output | 4 | Identification value: bits 3:1 source code, bit 0 active-low pending |
| irq | output | 1 | Interrupt request, active high |

## Verification
The properties take for granted that the strobes come from a single bus access, so at most one of `lsr_rd`, `iir_rd` and `thr_wr` is high in a cycle. They also assume `frame_bits` is non-zero whenever a push or pop restarts the timer. The bench drives every strobe as a single-cycle pulse on its own and keeps `frame_bits` at 1 or 7. The bench also holds `ier` steady across any cycle that follows an error event, because the set-side property reads the enable one cycle later.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_THRE = 3'd1,
        SRC_RDA  = 3'd2,
        SRC_RLS  = 3'd3,
        SRC_CTO  = 3'd6
    } irq_src_e;

    typedef struct packed {
        logic rls;
        logic rda;
        logic cto;
        logic thre;
    } irq_req_s;

    localparam int TICKS_PER_BIT = 16;
    localparam int IDLE_CHARS    = 4;
    localparam int IDLE_SHIFT    = $clog2(TICKS_PER_BIT * IDLE_CHARS);

    function automatic int trig_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_iid_idle_timer.sv
module uart_iid_idle_timer
    import uart_iid_pkg::*;
#(
    parameter int LVL_W   = 5,
    parameter int FRAME_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               baud_tick,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               timeout
);
    localparam int TMR_W = FRAME_W + IDLE_SHIFT + 1;

    logic [TMR_W-1:0] count;
    logic [TMR_W-1:0] limit;
    logic             has_data;
    logic             restart;

    assign limit    = TMR_W'(frame_bits) * TMR_W'(TICKS_PER_BIT * IDLE_CHARS);
    assign has_data = |rx_level;
    assign restart  = rx_push | rx_pop | ~has_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (baud_tick && (count < limit)) begin
            count <= count + 1'b1;
        end
    end

    assign timeout = has_data && (count >= limit);

endmodule

// File: rtl/uart_iid_thre_track.sv
module uart_iid_thre_track (
    input  logic clk,
    input  logic rst,
    input  logic thr_empty,
    input  logic enable,
    input  logic thr_wr,
    input  logic iir_rd,
    input  logic reported,
    output logic pending
);
    logic armed;
    logic armed_q;

    assign armed = thr_empty & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            pending <= 1'b0;
        end else begin
            armed_q <= armed;
            if (thr_wr || (iir_rd && reported)) begin
                pending <= 1'b0;
            end else if (armed && !armed_q) begin
                pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
    import uart_iid_pkg::*;
(
    input  irq_req_s req,
    output irq_src_e src
);
    always_comb begin
        if (req.rls) begin
            src = SRC_RLS;
        end else if (req.rda) begin
            src = SRC_RDA;
        end else if (req.cto) begin
            src = SRC_CTO;
        end else if (req.thre) begin
            src = SRC_THRE;
        end else begin
            src = SRC_NONE;
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_iid_pkg::*;
#(
    parameter int LVL_W   = 5,
    parameter int FRAME_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         ier,
    input  logic [1:0]         trig_sel,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               rx_err_set,
    input  logic               lsr_rd,
    input  logic               iir_rd,
    input  logic               thr_empty,
    input  logic               thr_wr,
    input  logic               baud_tick,
    output logic [3:0]         iir,
    output logic               irq
);
    logic     rls_flag;
    logic     cto_hit;
    logic     thre_flag;
    logic     rda_hit;
    irq_req_s req;
    irq_src_e src;

    always_ff @(posedge clk) begin
        if (rst) begin
            rls_flag <= 1'b0;
        end else if (rx_err_set) begin
            rls_flag <= 1'b1;
        end else if (lsr_rd) begin
            rls_flag <= 1'b0;
        end
    end

    assign rda_hit = int'(rx_level) >= trig_bytes(trig_sel);

    uart_iid_idle_timer #(
        .LVL_W   (LVL_W),
        .FRAME_W (FRAME_W)
    ) u_idle (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .rx_push    (rx_push),
        .rx_pop     (rx_pop),
        .rx_level   (rx_level),
        .frame_bits (frame_bits),
        .timeout    (cto_hit)
    );

    uart_iid_thre_track u_thre (
        .clk       (clk),
        .rst       (rst),
        .thr_empty (thr_empty),
        .enable    (ier[1]),
        .thr_wr    (thr_wr),
        .iir_rd    (iir_rd),
        .reported  (src == SRC_THRE),
        .pending   (thre_flag)
    );

    always_comb begin
        req.rls  = rls_flag  & ier[2];
        req.rda  = rda_hit   & ier[0];
        req.cto  = cto_hit   & ier[0];
        req.thre = thre_flag & ier[1];
    end

    uart_iid_prio u_prio (
        .req (req),
        .src (src)
    );

    assign irq = (src != SRC_NONE);
    assign iir = {src, ~irq};

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
    import uart_iid_pkg::*;
#(
    parameter int LVL_W   = 5,
    parameter int FRAME_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         ier,
    input logic [1:0]         trig_sel,
    input logic [FRAME_W-1:0] frame_bits,
    input logic [LVL_W-1:0]   rx_level,
    input logic               rx_push,
    input logic               rx_pop,
    input logic               rx_err_set,
    input logic               lsr_rd,
    input logic               thr_wr,
    input logic [3:0]         iir
);
    // R3
    rls_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_err_set && ier[2]) |=> (!ier[2] || iir == 4'b0110));

    // R3
    rls_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !rx_err_set) |=> (iir[3:1] != 3'd3));

    // R4
    rda_level_chk: assert property (@(posedge clk) disable iff (rst)
        (ier[0] && int'(rx_level) >= trig_bytes(trig_sel)) |-> (iir[3:1] == 3'd2 || iir[3:1] == 3'd3));

    // R6
    cto_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        (iir[3:1] == 3'd6) |-> (rx_level != '0));

    // R7
    cto_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push || rx_pop) |=> (frame_bits == '0 || iir[3:1] != 3'd6));

    // R8
    thre_write_chk: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> (iir[3:1] != 3'd1));

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (iir[3:1] == 3'd0 || iir[3:1] == 3'd1 || iir[3:1] == 3'd2 ||
         iir[3:1] == 3'd3 || iir[3:1] == 3'd6));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(
    .LVL_W   (LVL_W),
    .FRAME_W (FRAME_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .ier        (ier),
    .trig_sel   (trig_sel),
    .frame_bits (frame_bits),
    .rx_level   (rx_level),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .rx_err_set (rx_err_set),
    .lsr_rd     (lsr_rd),
    .thr_wr     (thr_wr),
    .iir        (iir)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
    localparam int LVL_W   = 5;
    localparam int FRAME_W = 4;

    logic               clk = 1'b0;
    logic               rst;
    logic [2:0]         ier;
    logic [1:0]         trig_sel;
    logic [FRAME_W-1:0] frame_bits;
    logic [LVL_W-1:0]   rx_level;
    logic               rx_push, rx_pop, rx_err_set, lsr_rd, iir_rd;
    logic               thr_empty, thr_wr, baud_tick;
    logic [3:0]         iir;
    logic               irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    uart_irq_ident #(.LVL_W(LVL_W), .FRAME_W(FRAME_W)) i_uart_irq_ident (
        .clk(clk), .rst(rst), .ier(ier), .trig_sel(trig_sel),
        .frame_bits(frame_bits), .rx_level(rx_level), .rx_push(rx_push),
        .rx_pop(rx_pop), .rx_err_set(rx_err_set), .lsr_rd(lsr_rd),
        .iir_rd(iir_rd), .thr_empty(thr_empty), .thr_wr(thr_wr),
        .baud_tick(baud_tick), .iir(iir), .irq(irq)
    );

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; ier = '0; trig_sel = '0; frame_bits = 4'd7; rx_level = '0;
        rx_push = 0; rx_pop = 0; rx_err_set = 0; lsr_rd = 0; iir_rd = 0;
        thr_empty = 0; thr_wr = 0; baud_tick = 0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk(iir, 4'b0001, "R1 iir after reset");
        chk({3'b0, irq}, 4'b0000, "R1 irq after reset");
    endtask

    task automatic t_rls();
        ier = 3'b100;
        rx_err_set = 1; cyc(1); rx_err_set = 0;
        chk(iir, 4'b0110, "R3 line status reported");
        chk({3'b0, irq}, 4'b0001, "R2 irq high when pending");
        cyc(5);
        chk(iir, 4'b0110, "R3 line status held");
        lsr_rd = 1; cyc(1); lsr_rd = 0;
        chk(iir, 4'b0001, "R3 cleared by status read");
        chk({3'b0, irq}, 4'b0000, "R2 irq low when idle");
    endtask

    task automatic t_rda();
        ier = 3'b001;
        for (int s = 0; s < 4; s++) begin
            int lv;
            lv = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            trig_sel = 2'(s);
            rx_level = LVL_W'(lv - 1); #1;
            chk(iir, 4'b0001, "R5 below trigger");
            rx_level = LVL_W'(lv); #1;
            chk(iir, 4'b0100, "R4 R5 at trigger");
            rx_level = LVL_W'(lv + 1); #1;
            chk(iir, 4'b0100, "R4 above trigger");
            rx_level = LVL_W'(lv - 1); #1;
            chk(iir, 4'b0001, "R4 drops below trigger");
            rx_level = '0;
            cyc(1);
        end
    endtask

    task automatic t_cto();
        ier = 3'b001; trig_sel = 2'd3; frame_bits = 4'd7; rx_level = 5'd2;
        rx_push = 1; cyc(1); rx_push = 0;
        cyc(500);
        chk(iir, 4'b0001, "R12 no advance without ticks");
        baud_tick = 1;
        cyc(447);
        chk(iir, 4'b0001, "R6 one tick before timeout");
        cyc(1);
        chk(iir, 4'b1100, "R6 timeout at 448 ticks");
        cyc(10);
        chk(iir, 4'b1100, "R6 timeout held");
        rx_pop = 1; cyc(1); rx_pop = 0;
        chk(iir, 4'b0001, "R7 cleared by pop");
        cyc(447);
        chk(iir, 4'b0001, "R7 restart count short");
        cyc(1);
        chk(iir, 4'b1100, "R7 restart count full");
        rx_push = 1; cyc(1); rx_push = 0;
        chk(iir, 4'b0001, "R7 cleared by push");
        baud_tick = 0; rx_level = '0;
        cyc(1);
    endtask

    task automatic t_enable();
        ier = 3'b000; trig_sel = 2'd3;
        rx_err_set = 1; cyc(1); rx_err_set = 0;
        rx_level = 5'd14; #1;
        chk(iir, 4'b0001, "R11 all sources masked");
        ier = 3'b100; #1;
        chk(iir, 4'b0110, "R11 latched line status unmasked");
        cyc(1);
        lsr_rd = 1; cyc(1); lsr_rd = 0;
        ier = 3'b001; #1;
        chk(iir, 4'b0100, "R11 data available unmasked");
        rx_level = '0; ier = 3'b000;
        cyc(1);
    endtask

    task automatic t_thre();
        ier = 3'b010; thr_empty = 0;
        cyc(2);
        chk(iir, 4'b0001, "R8 idle while holding full");
        thr_empty = 1; cyc(1);
        chk(iir, 4'b0010, "R8 raised on empty");
        iir_rd = 1; cyc(1); iir_rd = 0;
        chk(iir, 4'b0001, "R8 cleared by ident read");
        thr_empty = 0; cyc(1); thr_empty = 1; cyc(1);
        chk(iir, 4'b0010, "R8 raised again");
        thr_wr = 1; cyc(1); thr_wr = 0;
        chk(iir, 4'b0001, "R8 cleared by holding write");
        ier = 3'b000; cyc(1); ier = 3'b010; cyc(1);
        chk(iir, 4'b0010, "R11 enable while empty raises");
        thr_wr = 1; cyc(1); thr_wr = 0;
    endtask

    task automatic t_prio();
        ier = 3'b111;
        thr_empty = 0; cyc(1); thr_empty = 1; cyc(1);
        chk(iir, 4'b0010, "R10 transmit empty alone");
        trig_sel = 2'd0; rx_level = 5'd1; #1;
        chk(iir, 4'b0100, "R10 data available over transmit empty");
        cyc(1);
        rx_err_set = 1; cyc(1); rx_err_set = 0;
        chk(iir, 4'b0110, "R10 line status over data available");
        iir_rd = 1; cyc(1); iir_rd = 0;
        chk(iir, 4'b0110, "R9 ident read keeps line status");
        lsr_rd = 1; cyc(1); lsr_rd = 0;
        chk(iir, 4'b0100, "R10 data available after status read");
        rx_level = '0; #1;
        chk(iir, 4'b0010, "R9 transmit empty survived reads");
        frame_bits = 4'd1; trig_sel = 2'd1; rx_level = 5'd1; baud_tick = 1;
        cyc(70);
        chk(iir, 4'b1100, "R10 timeout over transmit empty");
        baud_tick = 0; rx_level = '0; #1;
        chk(iir, 4'b0010, "R10 transmit empty after timeout");
        cyc(1);
        iir_rd = 1; cyc(1); iir_rd = 0;
        chk(iir, 4'b0001, "R8 cleared when reported");
    endtask

    initial begin
        t_reset();
        t_rls();
        t_rda();
        t_cto();
        t_enable();
        t_thre();
        t_prio();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog for all requirements: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule